// File: doc/BRIEF.md
# Dual-Bank Command Decoder and Configuration Control

This block is the command front end of a content-addressable memory device. It accepts 16-bit command words on a write port, decodes them and keeps the configuration registers. Each configuration register exists twice, once in a foreground bank and once in a background bank. Two select instructions choose which bank is live, and register loads, readback and address updates act only on the live bank. A task can park its settings in one bank and switch back to them in a single command.

Memory accesses come in two forms. A single-word form uses the address already held in the live bank. A two-word form takes its address from the command word that follows. After every access the live address register steps up, steps down or holds, as the live control register selects. The block sends the memory array an access strobe together with the address used. A non-reset write to the control register raises a compare-trigger pulse. A control write with bit 15 clear resets the whole front end and raises a reset pulse instead.

Command word layout: bits 15:12 hold the opcode. 0x1 selects the foreground bank and 0x2 selects the background bank. 0x3 loads a register: bits 2:0 give the register code, and the next command word is the value. 0x4 starts a memory access, and its bit 11 is the address-follows flag. All other opcodes do nothing. Register codes are 0 control, 1 segment control, 2 address, 3 mask, 4 persistent source and 5 persistent destination. Codes 6 and 7 do nothing. In the control register, bits 3:2 give the address step (00 hold, 01 increment, 10 decrement, 11 hold) and bits 1:0 give the operating mode (01 is standard).

Top module: `dual_bank_cmd_ctrl`

## Requirements
- R1: After reset the foreground bank is live (`active_bank`=0) and no access is pending. `mem_acc`, `cmp_trig` and `dev_rst` are low. Readback gives 0x0001 for control and 0 for every other code, including codes 6 and 7.
- R2: Opcode 0x1 makes the foreground bank live and opcode 0x2 makes the background bank live, from the next cycle on. Readback and register loads reach only the live bank.
- R3: Opcode 0x3 with code c stores the following command word into register c of the live bank. The address register keeps the low 10 bits. Control bit 15 always reads back as 0. Codes 6 and 7, and opcodes other than 0x1 to 0x4, change nothing.
- R4: A control load whose data has bit 15 = 0 ignores its other bits. It returns both banks to the reset values of R1, makes the foreground bank live, and gives a one-cycle `dev_rst` pulse in the next cycle with no `cmp_trig`.
- R5: A control load whose data has bit 15 = 1 gives a one-cycle `cmp_trig` pulse in the cycle after the data word.
- R6: Opcode 0x4 with bit 11 = 0 gives a one-cycle `mem_acc` in the next cycle, with `mem_addr` equal to the live bank's address register.
- R7: Opcode 0x4 with bit 11 = 1 performs no access of its own. The next command word is taken as an address, whatever its bits are, and is never decoded as an instruction. Its low 10 bits appear on `mem_addr` with `mem_acc` in the following cycle.
- R8: After each access the live address register becomes the accessed address plus one (step 01) or minus one (step 10), wrapping between 0x3FF and 0x000. With step 00 or 11 it becomes the accessed address unchanged.
- R9: Cycles with `cmd_valid` low leave all state unchanged, including a pending second word, and produce no pulses.
- R10: An access updates only the live bank's address register. The other bank's address register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word present this cycle |
| cmd_data | input | 16 | Command word |
| rd_sel | input | 3 | Register code for readback |
| rd_data | output | 16 | Live-bank register selected by `rd_sel` |
| active_bank | output | 1 | 0 foreground, 1 background |
| mem_acc | output | 1 | One-cycle memory access strobe |
| mem_addr | output | 10 | Address of the access |
| cmp_trig | output | 1 | One-cycle compare trigger |
| dev_rst | output | 1 | One-cycle device reset pulse |

## Verification
Two things can land on the same clock edge: loading the address register from the second word of a two-word access, and the post-access step. The step must then act on the freshly loaded address, not on the stale one. The bench forces this case with increment set and a trailing word of 0x03FF. It expects `mem_addr`=0x3FF and a readback of 0x000, and random command streams revisit the case against the reference model on every clock. A second collision sets a soft reset issued from the background bank against the foreground bank's contents. It is judged by reading back both banks afterwards.

// File: rtl/cmdfe_pkg.sv
package cmdfe_pkg;
  localparam int CMD_W     = 16;
  localparam int OP_MSB    = 15;
  localparam int OP_LSB    = 12;
  localparam int AFLAG_BIT = 11;
  localparam int REG_SEL_W = 3;
  localparam int CTL_W     = CMD_W - 1;
  localparam int NUM_BANKS = 2;

  localparam logic [CTL_W-1:0] CTL_RST = CTL_W'(1);

  typedef enum logic [3:0] {
    OP_NOP    = 4'h0,
    OP_SEL_FG = 4'h1,
    OP_SEL_BG = 4'h2,
    OP_LOAD   = 4'h3,
    OP_ACCESS = 4'h4
  } op_e;

  typedef enum logic [1:0] {
    PND_IDLE = 2'd0,
    PND_ADDR = 2'd1,
    PND_LOAD = 2'd2
  } pend_e;

  localparam logic [REG_SEL_W-1:0] RG_CTL = 3'd0;
  localparam logic [REG_SEL_W-1:0] RG_SEG = 3'd1;
  localparam logic [REG_SEL_W-1:0] RG_ADR = 3'd2;
  localparam logic [REG_SEL_W-1:0] RG_MSK = 3'd3;
  localparam logic [REG_SEL_W-1:0] RG_SRC = 3'd4;
  localparam logic [REG_SEL_W-1:0] RG_DST = 3'd5;

  localparam logic [1:0] STEP_INC = 2'b01;
  localparam logic [1:0] STEP_DEC = 2'b10;
endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import cmdfe_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid_i,
  input  logic [CMD_W-1:0]     cmd_data_i,
  output logic                 sel_fg_o,
  output logic                 sel_bg_o,
  output logic                 reg_we_o,
  output logic [REG_SEL_W-1:0] reg_sel_o,
  output logic [CMD_W-1:0]     reg_wdata_o,
  output logic                 soft_rst_o,
  output logic                 acc_now_o,
  output logic                 acc_ld_o,
  output logic [ADDR_W-1:0]    ld_addr_o,
  output logic                 pend_busy_o
);

  pend_e                pend_q, pend_d;
  logic [REG_SEL_W-1:0] preg_q, preg_d;
  op_e                  op;

  assign op = op_e'(cmd_data_i[OP_MSB:OP_LSB]);

  always_comb begin
    pend_d     = pend_q;
    preg_d     = preg_q;
    sel_fg_o   = 1'b0;
    sel_bg_o   = 1'b0;
    reg_we_o   = 1'b0;
    soft_rst_o = 1'b0;
    acc_now_o  = 1'b0;
    acc_ld_o   = 1'b0;
    if (cmd_valid_i) begin
      unique case (pend_q)
        PND_ADDR: begin
          acc_ld_o = 1'b1;
          pend_d   = PND_IDLE;
        end
        PND_LOAD: begin
          pend_d = PND_IDLE;
          if (preg_q == RG_CTL && !cmd_data_i[CMD_W-1]) soft_rst_o = 1'b1;
          else                                           reg_we_o   = 1'b1;
        end
        default: begin
          case (op)
            OP_SEL_FG: sel_fg_o = 1'b1;
            OP_SEL_BG: sel_bg_o = 1'b1;
            OP_LOAD: begin
              pend_d = PND_LOAD;
              preg_d = cmd_data_i[REG_SEL_W-1:0];
            end
            OP_ACCESS: begin
              if (cmd_data_i[AFLAG_BIT]) pend_d    = PND_ADDR;
              else                       acc_now_o = 1'b1;
            end
            default: ;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= PND_IDLE;
      preg_q <= '0;
    end else if (cmd_valid_i) begin
      pend_q <= pend_d;
      preg_q <= preg_d;
    end
  end

  assign reg_sel_o   = preg_q;
  assign reg_wdata_o = cmd_data_i;
  assign ld_addr_o   = cmd_data_i[ADDR_W-1:0];
  assign pend_busy_o = (pend_q != PND_IDLE);

endmodule

// File: rtl/addr_stepper.sv
module addr_stepper
  import cmdfe_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        mode_i,
  output logic [ADDR_W-1:0] addr_o
);

  always_comb begin
    unique case (mode_i)
      STEP_INC: addr_o = addr_i + ADDR_W'(1);
      STEP_DEC: addr_o = addr_i - ADDR_W'(1);
      default:  addr_o = addr_i;
    endcase
  end

endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import cmdfe_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_i,
  input  logic                 wr_en_i,
  input  logic [REG_SEL_W-1:0] wr_sel_i,
  input  logic [CMD_W-1:0]     wr_data_i,
  input  logic                 step_en_i,
  input  logic [ADDR_W-1:0]    step_val_i,
  output logic [CTL_W-1:0]     ctl_o,
  output logic [CMD_W-1:0]     seg_o,
  output logic [ADDR_W-1:0]    adr_o,
  output logic [CMD_W-1:0]     msk_o,
  output logic [CMD_W-1:0]     src_o,
  output logic [CMD_W-1:0]     dst_o
);

  logic [CTL_W-1:0]  ctl_q, ctl_d;
  logic [CMD_W-1:0]  seg_q, seg_d, msk_q, msk_d, src_q, src_d, dst_q, dst_d;
  logic [ADDR_W-1:0] adr_q, adr_d;
  logic              upd;

  assign upd = clr_i | wr_en_i | step_en_i;

  always_comb begin
    ctl_d = ctl_q;
    seg_d = seg_q;
    adr_d = adr_q;
    msk_d = msk_q;
    src_d = src_q;
    dst_d = dst_q;
    if (clr_i) begin
      ctl_d = CTL_RST;
      seg_d = '0;
      adr_d = '0;
      msk_d = '0;
      src_d = '0;
      dst_d = '0;
    end else begin
      if (wr_en_i) begin
        case (wr_sel_i)
          RG_CTL:  ctl_d = wr_data_i[CTL_W-1:0];
          RG_SEG:  seg_d = wr_data_i;
          RG_ADR:  adr_d = wr_data_i[ADDR_W-1:0];
          RG_MSK:  msk_d = wr_data_i;
          RG_SRC:  src_d = wr_data_i;
          RG_DST:  dst_d = wr_data_i;
          default: ;
        endcase
      end
      if (step_en_i) adr_d = step_val_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_RST;
      seg_q <= '0;
      adr_q <= '0;
      msk_q <= '0;
      src_q <= '0;
      dst_q <= '0;
    end else if (upd) begin
      ctl_q <= ctl_d;
      seg_q <= seg_d;
      adr_q <= adr_d;
      msk_q <= msk_d;
      src_q <= src_d;
      dst_q <= dst_d;
    end
  end

  assign ctl_o = ctl_q;
  assign seg_o = seg_q;
  assign adr_o = adr_q;
  assign msk_o = msk_q;
  assign src_o = src_q;
  assign dst_o = dst_q;

endmodule

// File: rtl/dual_bank_cmd_ctrl.sv
module dual_bank_cmd_ctrl
  import cmdfe_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [CMD_W-1:0]     cmd_data,
  input  logic [REG_SEL_W-1:0] rd_sel,
  output logic [CMD_W-1:0]     rd_data,
  output logic                 active_bank,
  output logic                 mem_acc,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic                 cmp_trig,
  output logic                 dev_rst
);

  localparam int PAD_W = CMD_W - ADDR_W;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic                 sel_fg, sel_bg, reg_we, soft_rst, acc_now, acc_ld, pend_busy;
  logic [REG_SEL_W-1:0] reg_sel;
  logic [CMD_W-1:0]     reg_wdata;
  logic [ADDR_W-1:0]    ld_addr;

  cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cmd_valid_i (cmd_valid),
    .cmd_data_i  (cmd_data),
    .sel_fg_o    (sel_fg),
    .sel_bg_o    (sel_bg),
    .reg_we_o    (reg_we),
    .reg_sel_o   (reg_sel),
    .reg_wdata_o (reg_wdata),
    .soft_rst_o  (soft_rst),
    .acc_now_o   (acc_now),
    .acc_ld_o    (acc_ld),
    .ld_addr_o   (ld_addr),
    .pend_busy_o (pend_busy)
  );

  logic bank_q, bank_d;

  always_comb begin
    bank_d = bank_q;
    if (soft_rst)    bank_d = 1'b0;
    else if (sel_fg) bank_d = 1'b0;
    else if (sel_bg) bank_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) bank_q <= 1'b0;
    else            bank_q <= bank_d;
  end

  logic [CTL_W-1:0]  ctl_w [NUM_BANKS];
  logic [CMD_W-1:0]  seg_w [NUM_BANKS];
  logic [ADDR_W-1:0] adr_w [NUM_BANKS];
  logic [CMD_W-1:0]  msk_w [NUM_BANKS];
  logic [CMD_W-1:0]  src_w [NUM_BANKS];
  logic [CMD_W-1:0]  dst_w [NUM_BANKS];

  logic              acc_any;
  logic [ADDR_W-1:0] acc_base, acc_next;

  assign acc_any  = acc_now | acc_ld;
  assign acc_base = acc_ld ? ld_addr : adr_w[bank_q];

  addr_stepper #(.ADDR_W(ADDR_W)) u_step (
    .addr_i (acc_base),
    .mode_i (ctl_w[bank_q][3:2]),
    .addr_o (acc_next)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic live;
    assign live = (bank_q == 1'(g));
    cfg_bank #(.ADDR_W(ADDR_W)) u_bank (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .clr_i      (soft_rst),
      .wr_en_i    (reg_we & live),
      .wr_sel_i   (reg_sel),
      .wr_data_i  (reg_wdata),
      .step_en_i  (acc_any & live),
      .step_val_i (acc_next),
      .ctl_o      (ctl_w[g]),
      .seg_o      (seg_w[g]),
      .adr_o      (adr_w[g]),
      .msk_o      (msk_w[g]),
      .src_o      (src_w[g]),
      .dst_o      (dst_w[g])
    );
  end

  logic              acc_q, cmp_q, rst_q;
  logic [ADDR_W-1:0] addr_q;
  logic              cmp_d;

  assign cmp_d = reg_we & (reg_sel == RG_CTL);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      acc_q <= 1'b0;
      cmp_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      acc_q <= acc_any;
      cmp_q <= cmp_d;
      rst_q <= soft_rst;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   addr_q <= '0;
    else if (acc_any) addr_q <= acc_base;
  end

  always_comb begin
    case (rd_sel)
      RG_CTL:  rd_data = {1'b0, ctl_w[bank_q]};
      RG_SEG:  rd_data = seg_w[bank_q];
      RG_ADR:  rd_data = {{PAD_W{1'b0}}, adr_w[bank_q]};
      RG_MSK:  rd_data = msk_w[bank_q];
      RG_SRC:  rd_data = src_w[bank_q];
      RG_DST:  rd_data = dst_w[bank_q];
      default: rd_data = '0;
    endcase
  end

  assign active_bank = bank_q;
  assign mem_acc     = acc_q;
  assign mem_addr    = addr_q;
  assign cmp_trig    = cmp_q;
  assign dev_rst     = rst_q;

endmodule

// File: rtl/dual_bank_cmd_ctrl_chk.sv
module dual_bank_cmd_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [3:0] cmd_op,
  input logic       pend_busy,
  input logic       active_bank,
  input logic       mem_acc,
  input logic       cmp_trig,
  input logic       dev_rst
);

  // R5
  cmp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_trig |=> !cmp_trig);

  // R4
  rst_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst |-> (!cmp_trig && !active_bank && !pend_busy));

  // R6
  acc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_acc |-> $past(cmd_valid));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> (!mem_acc && !cmp_trig && !dev_rst && $stable(active_bank)));

  // R7
  pend_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && pend_busy) |=> !pend_busy);

  // R2
  sel_bg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !pend_busy && cmd_op == 4'h2) |=> active_bank);

  // R2
  sel_fg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !pend_busy && cmd_op == 4'h1) |=> !active_bank);

endmodule

bind dual_bank_cmd_ctrl dual_bank_cmd_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_op      (cmd_data[15:12]),
  .pend_busy   (pend_busy),
  .active_bank (active_bank),
  .mem_acc     (mem_acc),
  .cmp_trig    (cmp_trig),
  .dev_rst     (dev_rst)
);

// File: tb/dual_bank_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module dual_bank_cmd_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [15:0] cmd_data;
  logic [2:0]  rd_sel;
  logic [15:0] rd_data;
  logic        active_bank, mem_acc, cmp_trig, dev_rst;
  logic [9:0]  mem_addr;

  always #4 clk = ~clk;

  dual_bank_cmd_ctrl u_dual_bank_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .active_bank(active_bank),
    .mem_acc(mem_acc), .mem_addr(mem_addr), .cmp_trig(cmp_trig), .dev_rst(dev_rst)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  string cur = "R1";

  // behavioural reference state
  int m_reg [2][6];
  int m_act, m_pend, m_preg;
  int e_acc, e_addr, e_cmp, e_rst;

  function automatic int step_addr(int a, int ctl);
    int md = (ctl >> 2) & 3;
    if (md == 1) return (a + 1) % 1024;
    if (md == 2) return (a + 1023) % 1024;
    return a;
  endfunction

  task automatic m_reset();
    for (int b = 0; b < 2; b++) begin
      for (int r = 0; r < 6; r++) m_reg[b][r] = 0;
      m_reg[b][0] = 1;
    end
    m_act = 0; m_pend = 0; m_preg = 0;
  endtask

  task automatic m_access(int a);
    e_acc  = 1;
    e_addr = a;
    m_reg[m_act][2] = step_addr(a, m_reg[m_act][0]);
  endtask

  task automatic m_word(int w);
    if (m_pend == 1) begin
      m_pend = 0;
      m_access(w & 'h3FF);
    end else if (m_pend == 2) begin
      m_pend = 0;
      if (m_preg == 0) begin
        if (((w >> 15) & 1) == 0) begin
          m_reset();
          e_rst = 1;
        end else begin
          m_reg[m_act][0] = w & 'h7FFF;
          e_cmp = 1;
        end
      end else if (m_preg == 2) m_reg[m_act][2] = w & 'h3FF;
      else if (m_preg < 6) m_reg[m_act][m_preg] = w;
    end else begin
      case ((w >> 12) & 'hF)
        1: m_act = 0;
        2: m_act = 1;
        3: begin m_pend = 2; m_preg = w & 7; end
        4: if (((w >> 11) & 1) == 1) m_pend = 1;
           else m_access(m_reg[m_act][2]);
        default: ;
      endcase
    end
  endtask

  function automatic int m_read(int s);
    if (s < 6) return m_reg[m_act][s];
    return 0;
  endfunction

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", cur, what, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("active_bank", int'(active_bank), m_act);
    chk("mem_acc", int'(mem_acc), e_acc);
    if (e_acc == 1) chk("mem_addr", int'(mem_addr), e_addr);
    chk("cmp_trig", int'(cmp_trig), e_cmp);
    chk("dev_rst", int'(dev_rst), e_rst);
    chk("rd_data", int'(rd_data), m_read(int'(rd_sel)));
  endtask

  // drive at falling edge, model the rising edge, compare at next falling edge
  task automatic cyc(bit v, int w, int s);
    cmd_valid = v;
    cmd_data  = 16'(w);
    rd_sel    = 3'(s);
    @(posedge clk);
    e_acc = 0; e_cmp = 0; e_rst = 0;
    if (v) m_word(w);
    @(negedge clk);
    cmp_all();
  endtask

  task automatic read_all();
    for (int s = 0; s < 8; s++) cyc(1'b0, 0, s);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_data = '0; rd_sel = '0;
    m_reset(); e_acc = 0; e_cmp = 0; e_rst = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state on every readback code
    cur = "R1"; read_all();

    // R3: load every foreground register
    cur = "R3";
    cyc(1, 'h3001, 1); cyc(1, 'hA5A5, 1);
    cyc(1, 'h3002, 2); cyc(1, 'hFBFE, 2);
    cyc(1, 'h3003, 3); cyc(1, 'h1234, 3);
    cyc(1, 'h3004, 4); cyc(1, 'hBEEF, 4);
    cyc(1, 'h3005, 5); cyc(1, 'h0F0F, 5);
    // R5: non-reset control write, increment step
    cur = "R5"; cyc(1, 'h3000, 0); cyc(1, 'h8004, 0); cyc(0, 0, 0);
    cur = "R3"; read_all();

    // R6 and R8: single-word access with wrap at top
    cur = "R6"; cyc(1, 'h4000, 2); cyc(1, 'h4000, 2);
    cur = "R8"; cyc(0, 0, 2);

    // R2: background bank is separate
    cur = "R2"; cyc(1, 'h2000, 0); read_all();
    cyc(1, 'h3000, 0); cyc(1, 'h8008, 0);
    cyc(1, 'h3002, 2); cyc(1, 'h0000, 2);
    // R8: decrement wraps at bottom
    cur = "R8"; cyc(1, 'h4000, 2); cyc(0, 0, 2);
    // R10: foreground address untouched by background access
    cur = "R10"; cyc(1, 'h1000, 2); cyc(0, 0, 2);

    // R7 and R9: address follows after idle cycles, word looks like an opcode
    cur = "R9"; cyc(1, 'h4800, 2); cyc(0, 0, 2); cyc(0, 0, 0);
    cur = "R7"; cyc(1, 'h2005, 2); cyc(0, 0, 2);

    // R3: ignored opcodes and register codes
    cur = "R3"; cyc(1, 'hF123, 0); cyc(1, 'h3006, 6); cyc(1, 'hFFFF, 6);
    cyc(1, 'h3007, 7); cyc(1, 'h1234, 7); read_all();

    // Collision: address load and step on one edge
    cur = "R8"; cyc(1, 'h3000, 0); cyc(1, 'h8004, 0);
    cyc(1, 'h4800, 2); cyc(1, 'h03FF, 2); cyc(0, 0, 2);

    // R4: soft reset issued from background clears both banks
    cur = "R4"; cyc(1, 'h2000, 0); cyc(1, 'h3001, 1); cyc(1, 'h5555, 1);
    cyc(1, 'h3000, 0); cyc(1, 'h7FFF, 0); read_all();
    cyc(1, 'h2000, 1); read_all(); cyc(1, 'h1000, 0);

    // random streams against the model
    cur = "R3";
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom % 16);
      int w;
      bit v = 1'b1;
      case (r)
        0, 1:       begin v = 1'b0; w = 0; end
        2:          w = 'h1000;
        3:          w = 'h2000;
        4, 5, 6:    w = 'h3000 | int'($urandom % 8);
        10, 11, 12: w = 'h4000 | (int'($urandom % 2) << 11);
        default:    w = int'($urandom & 'hFFFF);
      endcase
      cyc(v, w, i % 8);
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule